// File: doc/BRIEF.md
# Two-Stage Operand Pipeline Sequencer

This block is the control sequencer for a two-stage operand pipeline. Stage one decodes an instruction and reads its register operands, and stage two executes it. The block sees only a 16-bit opcode and a 2-bit instruction class. It does not model the datapath. It decides when a new instruction may enter, which pass each instruction is in, and when memory read and write strobes fire. It also flags opcodes that must trap instead of executing.

Instructions that read a memory operand go through both stages twice. The first pass forms the operand address. The second pass fetches the memory and register operands together and then executes. While the first pass is in stage one, the block holds off the next issue. A store does its address and data work in one pass, so the pipeline accepts an instruction every cycle. A read-modify-write runs as a load whose execute pass also writes memory. A memory-wait input freezes both stages in place. An opcode that traps is removed at the stage-one boundary. It never executes and never strobes memory.

Top module: `opnd_pipe_seq`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, every output is low: stage valids, phases, `hold_issue`, `mem_rd`, `mem_wr`, `exc_valid` and `exc_kind`. Asserting reset clears in-flight instructions at once.
- R2: A class 2'b00 instruction (register to register) accepted at a clock edge shows `s1_valid`=1 and `s1_phase`=0 in the next cycle. The cycle after that it shows `s2_valid`=1 and `s2_phase`=0. Neither strobe fires and `hold_issue` stays low.
- R3: A class 2'b01 instruction (load) shows `s1_valid`=1, `s1_phase`=0 and `hold_issue`=1 in the first cycle after acceptance. In the second cycle it shows `s1_phase`=1 with `mem_rd`=1 in stage one, and `s2_valid`=1 with `s2_phase`=0. In the third cycle it shows `s2_valid`=1 and `s2_phase`=1. `mem_wr` never fires, and an instruction offered while `hold_issue` is high is not taken.
- R4: A class 2'b10 instruction (store) makes a single pass with no hold. `mem_wr`=1 in the cycle it occupies stage two, and `mem_rd` stays low.
- R5: A class 2'b11 instruction (read-modify-write) follows the R3 sequence. In addition, `mem_wr`=1 in the cycle its second pass occupies stage two (`s2_phase`=1).
- R6: Opcodes 16'h0000 and 16'h4AFC raise `exc_valid` with `exc_kind`=2'b01, whatever the class. The instruction never reaches stage two, causes no `mem_rd` or `mem_wr`, and asserts no hold.
- R7: Any other opcode with bits [15:12] equal to 4'hA raises `exc_kind`=2'b10. Any other opcode with bits [15:12] equal to 4'hF raises `exc_kind`=2'b11. Both follow the same drop rules as R6.
- R8: Every other opcode, including near misses such as 16'h4AFD and 16'h0001, sequences by its class with `exc_kind`=2'b00.
- R9: While `mem_wait`=1, stage valids and phases hold their values, no instruction is accepted, `hold_issue`=1 and `exc_valid`=0. Sequencing resumes where it stopped once `mem_wait` falls.
- R10: Register-to-register instructions offered on consecutive cycles are all accepted, with `hold_issue` low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction is offered this cycle |
| issue_op | input | 16 | Opcode of the offered instruction |
| issue_cls | input | 2 | Class: 00 reg-reg, 01 load, 10 store, 11 read-modify-write |
| mem_wait | input | 1 | Memory not ready; freezes both stages |
| hold_issue | output | 1 | Offered instruction is not accepted this cycle |
| s1_valid | output | 1 | Stage one holds an instruction |
| s1_phase | output | 1 | Pass of the stage-one instruction (0 first, 1 second) |
| s2_valid | output | 1 | Stage two holds an instruction |
| s2_phase | output | 1 | Pass of the stage-two instruction |
| mem_rd | output | 1 | Memory operand read strobe |
| mem_wr | output | 1 | Memory write strobe |
| exc_valid | output | 1 | A trapping instruction is dropped this cycle |
| exc_kind | output | 2 | Trap kind: 01 illegal, 10 group A, 11 group F |

## Verification
A trap can be raised for a younger instruction in stage one in the same cycle that an older store writes memory from stage two. The bench provokes this by issuing a store and then 16'h0000 on the next cycle. It expects `mem_wr` and `exc_valid` (kind 01) high together. In the following cycle it expects stage two empty with no write, so the trap must neither cancel the older store nor leak a write of its own. A second directed case raises `mem_wait` while a trapping opcode sits in stage one. The trap must stay silent for the whole wait and fire exactly once after release.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

  localparam int CLS_W  = 2;
  localparam int KIND_W = 2;

  // bit0: needs a memory operand read pass; bit1: writes memory
  typedef enum logic [CLS_W-1:0] {
    CLS_REG   = 2'b00,
    CLS_LOAD  = 2'b01,
    CLS_STORE = 2'b10,
    CLS_RMW   = 2'b11
  } icls_e;

  typedef enum logic [KIND_W-1:0] {
    EXC_NONE    = 2'b00,
    EXC_ILLEGAL = 2'b01,
    EXC_GRP_A   = 2'b10,
    EXC_GRP_F   = 2'b11
  } exck_e;

  // stage-one slot: carries the trap kind decoded at issue
  typedef struct packed {
    logic  vld;
    logic  pass;
    icls_e cls;
    exck_e kind;
  } fslot_t;

  // stage-two slot: trapping instructions never get here
  typedef struct packed {
    logic  vld;
    logic  pass;
    icls_e cls;
  } bslot_t;

endpackage

// File: rtl/opseq_rst_sync.sv
module opseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = 1'b1;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/opseq_decode.sv
module opseq_decode
  import opseq_pkg::*;
#(
  parameter int            OP_W   = 16,
  parameter logic [OP_W-1:0] ILL_OP0 = 16'h0000,
  parameter logic [OP_W-1:0] ILL_OP1 = 16'h4AFC,
  parameter logic [3:0]    GRP_A  = 4'hA,
  parameter logic [3:0]    GRP_F  = 4'hF
) (
  input  logic [OP_W-1:0] op,
  output exck_e           kind
);

  localparam int NIB_W = 4;

  logic [NIB_W-1:0] top_nib;
  logic             hit_ill;

  assign top_nib = op[OP_W-1 -: NIB_W];
  assign hit_ill = (op == ILL_OP0) || (op == ILL_OP1);

  // exact illegal codes take priority over the group nibbles
  always_comb begin
    if (hit_ill)               kind = EXC_ILLEGAL;
    else if (top_nib == GRP_A) kind = EXC_GRP_A;
    else if (top_nib == GRP_F) kind = EXC_GRP_F;
    else                       kind = EXC_NONE;
  end

endmodule

// File: rtl/opseq_front.sv
module opseq_front
  import opseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adv,
  input  logic   accept,
  input  fslot_t new_slot,
  output fslot_t s1,
  output logic   recirc,
  output logic   exc_fire
);

  fslot_t s1_q;
  fslot_t s1_nxt;
  logic   s1_trap;

  assign s1_trap  = s1_q.vld && (s1_q.kind != EXC_NONE);
  // a clean memory-read instruction in its first pass re-enters stage one
  assign recirc   = s1_q.vld && !s1_trap && s1_q.cls[0] && !s1_q.pass;
  assign exc_fire = s1_trap && adv;

  always_comb begin
    s1_nxt = '0;
    if (recirc) begin
      s1_nxt      = s1_q;
      s1_nxt.pass = 1'b1;
    end else if (accept) begin
      s1_nxt = new_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   s1_q <= '0;
    else if (adv) s1_q <= s1_nxt;
  end

  assign s1 = s1_q;

  // R3
  recirc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recirc && adv) |=> (s1_q.vld && s1_q.pass));

  // R9
  front_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(s1_q));

endmodule

// File: rtl/opseq_back.sv
module opseq_back
  import opseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adv,
  input  fslot_t s1_in,
  output bslot_t s2,
  output logic   wr_stb
);

  bslot_t s2_q;
  bslot_t s2_nxt;

  always_comb begin
    s2_nxt = '0;
    if (s1_in.vld && (s1_in.kind == EXC_NONE)) begin
      s2_nxt.vld  = 1'b1;
      s2_nxt.pass = s1_in.pass;
      s2_nxt.cls  = s1_in.cls;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   s2_q <= '0;
    else if (adv) s2_q <= s2_nxt;
  end

  // store writes in its only pass; read-modify-write writes in its second
  assign wr_stb = s2_q.vld && s2_q.cls[1] && (s2_q.pass || !s2_q.cls[0]);
  assign s2     = s2_q;

  // R6
  trap_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s1_in.vld && (s1_in.kind != EXC_NONE)) |=> !s2_q.vld);

  // R5
  rmw_second_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s1_in.vld && (s1_in.kind == EXC_NONE) && (s1_in.cls == CLS_RMW) && s1_in.pass)
      |=> wr_stb);

endmodule

// File: rtl/opnd_pipe_seq.sv
module opnd_pipe_seq
  import opseq_pkg::*;
#(
  parameter int              OP_W        = 16,
  parameter logic [OP_W-1:0] ILL_OP0     = 16'h0000,
  parameter logic [OP_W-1:0] ILL_OP1     = 16'h4AFC,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [OP_W-1:0]   issue_op,
  input  logic [CLS_W-1:0]  issue_cls,
  input  logic              mem_wait,
  output logic              hold_issue,
  output logic              s1_valid,
  output logic              s1_phase,
  output logic              s2_valid,
  output logic              s2_phase,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              exc_valid,
  output logic [KIND_W-1:0] exc_kind
);

  logic   rst_q;
  logic   adv;
  logic   accept;
  logic   recirc;
  logic   exc_fire;
  exck_e  dec_kind;
  fslot_t new_slot;
  fslot_t s1;
  bslot_t s2;

  opseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q)
  );

  opseq_decode #(.OP_W(OP_W), .ILL_OP0(ILL_OP0), .ILL_OP1(ILL_OP1)) u_dec (
    .op   (issue_op),
    .kind (dec_kind)
  );

  assign adv        = !mem_wait;
  assign hold_issue = mem_wait || recirc;
  assign accept     = issue_valid && !hold_issue;

  always_comb begin
    new_slot      = '0;
    new_slot.vld  = 1'b1;
    new_slot.pass = 1'b0;
    new_slot.cls  = icls_e'(issue_cls);
    new_slot.kind = dec_kind;
  end

  opseq_front u_front (
    .clk      (clk),
    .rst_n    (rst_q),
    .adv      (adv),
    .accept   (accept),
    .new_slot (new_slot),
    .s1       (s1),
    .recirc   (recirc),
    .exc_fire (exc_fire)
  );

  opseq_back u_back (
    .clk    (clk),
    .rst_n  (rst_q),
    .adv    (adv),
    .s1_in  (s1),
    .s2     (s2),
    .wr_stb (mem_wr)
  );

  assign s1_valid  = s1.vld;
  assign s1_phase  = s1.pass;
  assign s2_valid  = s2.vld;
  assign s2_phase  = s2.pass;
  assign mem_rd    = s1.vld && s1.pass;
  assign exc_valid = exc_fire;
  assign exc_kind  = exc_fire ? s1.kind : EXC_NONE;

  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_q)
    mem_wait |=> $stable({s1_valid, s1_phase, s2_valid, s2_phase}));

  // R3
  rd_then_exec_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_rd && !mem_wait) |=> (s2_valid && s2_phase));

  // R6
  exc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    exc_valid |-> (!mem_rd && !hold_issue));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_q |-> (!s1_valid && !s2_valid && !mem_wr && !exc_valid));

endmodule

// File: tb/tb_opnd_pipe_seq.sv
`timescale 1ns/1ps
module tb_opnd_pipe_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic [15:0] issue_op;
  logic [1:0]  issue_cls;
  logic        mem_wait;
  logic        hold_issue, s1_valid, s1_phase, s2_valid, s2_phase;
  logic        mem_rd, mem_wr, exc_valid;
  logic [1:0]  exc_kind;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  opnd_pipe_seq dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_cls(issue_cls), .mem_wait(mem_wait), .hold_issue(hold_issue),
    .s1_valid(s1_valid), .s1_phase(s1_phase), .s2_valid(s2_valid),
    .s2_phase(s2_phase), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .exc_valid(exc_valid), .exc_kind(exc_kind)
  );

  // {opcode, class, expected trap kind}
  localparam logic [19:0] VEC [0:12] = '{
    {16'h1234, 2'b00, 2'b00},
    {16'h2000, 2'b01, 2'b00},
    {16'h3001, 2'b10, 2'b00},
    {16'h5100, 2'b11, 2'b00},
    {16'h0000, 2'b00, 2'b01},
    {16'h4AFC, 2'b01, 2'b01},
    {16'hA123, 2'b10, 2'b10},
    {16'hF00F, 2'b11, 2'b11},
    {16'hAFFF, 2'b00, 2'b10},
    {16'h4AFD, 2'b01, 2'b00},
    {16'hFFFF, 2'b10, 2'b11},
    {16'h0001, 2'b00, 2'b00},
    {16'h9ABC, 2'b11, 2'b00}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input bit e1v, input bit e1p, input bit e2v,
                         input bit e2p, input bit erd, input bit ewr, input bit eex,
                         input int ekind, input bit ehold);
    chk(req, "s1_valid",   int'(s1_valid),   int'(e1v));
    chk(req, "s1_phase",   int'(s1_phase),   int'(e1p));
    chk(req, "s2_valid",   int'(s2_valid),   int'(e2v));
    chk(req, "s2_phase",   int'(s2_phase),   int'(e2p));
    chk(req, "mem_rd",     int'(mem_rd),     int'(erd));
    chk(req, "mem_wr",     int'(mem_wr),     int'(ewr));
    chk(req, "exc_valid",  int'(exc_valid),  int'(eex));
    chk(req, "exc_kind",   int'(exc_kind),   ekind);
    chk(req, "hold_issue", int'(hold_issue), int'(ehold));
  endtask

  task automatic run_vec(input logic [15:0] op, input logic [1:0] cls, input logic [1:0] kind);
    string rq;
    bit two;
    two = (kind == 2'b00) && cls[0];
    if (kind == 2'b01)      rq = "R6";
    else if (kind != 2'b00) rq = "R7";
    else if (cls == 2'b00)  rq = "R2";
    else if (cls == 2'b01)  rq = "R3";
    else if (cls == 2'b10)  rq = "R4";
    else                    rq = "R5";
    @(negedge clk);
    issue_valid = 1'b1; issue_op = op; issue_cls = cls;
    @(negedge clk);
    chk_all(rq, 1, 0, 0, 0, 0, 0, kind != 2'b00, int'(kind), two);
    if (kind == 2'b00) chk("R8", "exc_kind clean", int'(exc_kind), 0);
    issue_valid = 1'b0;
    @(negedge clk);
    if (kind != 2'b00) begin
      chk_all(rq, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    end else if (!two) begin
      chk_all(rq, 0, 0, 1, 0, 0, cls[1], 0, 0, 0);
    end else begin
      chk_all(rq, 1, 1, 1, 0, 1, 0, 0, 0, 0);
      @(negedge clk);
      chk_all(rq, 0, 0, 1, 1, 0, cls[1], 0, 0, 0);
    end
    @(negedge clk);
    chk_all(rq, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; issue_valid = 1'b0; issue_op = '0; issue_cls = '0; mem_wait = 1'b0;
    repeat (2) @(negedge clk);
    // R1: quiet during reset, even with a request offered
    issue_valid = 1'b1;
    @(negedge clk);
    chk_all("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    issue_valid = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_all("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // table walk
    for (int i = 0; i < 13; i++) begin
      run_vec(VEC[i][19:4], VEC[i][3:2], VEC[i][1:0]);
    end

    // R10: three reg-reg back to back
    @(negedge clk);
    issue_valid = 1'b1; issue_cls = 2'b00; issue_op = 16'h1111;
    @(negedge clk);
    chk("R10", "hold c1", int'(hold_issue), 0);
    issue_op = 16'h2222;
    @(negedge clk);
    chk("R10", "hold c2", int'(hold_issue), 0);
    chk("R10", "s2 c2", int'(s2_valid), 1);
    issue_op = 16'h3333;
    @(negedge clk);
    chk("R10", "s2 c3", int'(s2_valid), 1);
    chk("R10", "s1 c3", int'(s1_valid), 1);
    issue_valid = 1'b0;
    @(negedge clk);
    chk("R10", "s2 c4", int'(s2_valid), 1);
    chk("R10", "s1 c4", int'(s1_valid), 0);
    @(negedge clk);

    // R3: reg-reg offered behind a load waits one cycle
    issue_valid = 1'b1; issue_cls = 2'b01; issue_op = 16'h2100;
    @(negedge clk);
    chk("R3", "hold behind load", int'(hold_issue), 1);
    issue_cls = 2'b00; issue_op = 16'h1000;
    @(negedge clk);
    chk_all("R3", 1, 1, 1, 0, 1, 0, 0, 0, 0);
    @(negedge clk);
    issue_valid = 1'b0;
    chk_all("R3", 1, 0, 1, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk_all("R3", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    @(negedge clk);

    // R9: wait during a load's second pass, reg-reg offered meanwhile
    issue_valid = 1'b1; issue_cls = 2'b01; issue_op = 16'h2200;
    @(negedge clk);
    issue_valid = 1'b0;
    @(negedge clk);
    chk_all("R9", 1, 1, 1, 0, 1, 0, 0, 0, 0);
    mem_wait = 1'b1; issue_valid = 1'b1; issue_cls = 2'b00; issue_op = 16'h1234;
    @(negedge clk);
    chk_all("R9", 1, 1, 1, 0, 1, 0, 0, 0, 1);
    @(negedge clk);
    chk_all("R9", 1, 1, 1, 0, 1, 0, 0, 0, 1);
    mem_wait = 1'b0;
    @(negedge clk);
    chk_all("R9", 1, 0, 1, 1, 0, 0, 0, 0, 0);
    issue_valid = 1'b0;
    @(negedge clk);
    chk_all("R9", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    @(negedge clk);

    // R9 with R6: trap held silent during wait, fires once after
    issue_valid = 1'b1; issue_cls = 2'b00; issue_op = 16'h0000;
    @(negedge clk);
    issue_valid = 1'b0;
    chk("R6", "exc before wait", int'(exc_valid), 1);
    mem_wait = 1'b1;
    #1;
    chk("R9", "exc masked", int'(exc_valid), 0);
    @(negedge clk);
    chk("R9", "exc still masked", int'(exc_valid), 0);
    chk("R9", "trap held in s1", int'(s1_valid), 1);
    mem_wait = 1'b0;
    #1;
    chk("R6", "exc after wait", int'(exc_valid), 1);
    chk("R6", "kind after wait", int'(exc_kind), 1);
    @(negedge clk);
    chk_all("R6", 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // same cycle: older store writes while younger opcode traps
    issue_valid = 1'b1; issue_cls = 2'b10; issue_op = 16'h3300;
    @(negedge clk);
    issue_cls = 2'b00; issue_op = 16'h0000;
    @(negedge clk);
    issue_valid = 1'b0;
    chk("R4", "store write beside trap", int'(mem_wr), 1);
    chk("R6", "trap beside store", int'(exc_valid), 1);
    @(negedge clk);
    chk("R6", "no write for trap", int'(mem_wr), 0);
    chk("R6", "trap not in s2", int'(s2_valid), 0);

    // R1: asynchronous reset clears an in-flight load
    issue_valid = 1'b1; issue_cls = 2'b11; issue_op = 16'h5000;
    @(negedge clk);
    issue_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk_all("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    do_reset();
    chk_all("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule